// File: doc/BRIEF.md
# Bit-Synchronous Receiver with SYN Hunt and Framing

This block takes a serial data stream that arrives one bit per receive-clock strobe, with no start or stop bits, and finds where the characters begin. After it is enabled it slides a window over the stream and compares the last eight received bits with a programmed sync pattern after every bit. A match fixes the character boundary. In double-pattern mode the character that follows must equal a second pattern before the link counts as framed. In external mode the internal comparison is switched off and a rising pulse on a jam-sync input fixes the boundary instead.

Once framed, the block assembles characters, drops sync characters when stripping is selected, and hands every other character to a holding register with a ready flag. It also keeps overrun, parity and sync-detected flags for the host. The host clears the ready flag with a data-read strobe and clears the sticky flags with a status-read strobe.

Top module: `syncrx_hunt`

## Requirements
- R1: After reset rx_data is zero and rx_ready, parity_err, overrun and syn_det are all low.
- R2: While rx_enable is low the receiver is idle and drops its framing, so no character is delivered and syn_det is not set. A rising edge of rx_enable starts a new hunt.
- R3: Bits are taken least significant first, so the first bit of a character lands in rx_data bit 0. In hunt, the eight most recent bits are compared with syn1 after every bit, so a match is found at any bit offset.
- R4: With double_syn low, a syn1 match ends the hunt and sets syn_det. The matched character is not delivered, and the next eight bits form the first character.
- R5: With double_syn high, the character after a syn1 match must equal syn2. If it does, framing is established and syn_det is set. If it does not, hunting resumes. Neither character is delivered, and the stream syn1, syn1, syn2 does not achieve framing.
- R6: Every character that is not withheld is loaded into rx_data and sets rx_ready. A data_rd pulse clears rx_ready.
- R7: Delivering a character while rx_ready is high, with no data_rd in that cycle, sets overrun. A status_rd pulse clears overrun.
- R8: With strip_en high, a character equal to syn1 is withheld, and in double mode so is a syn2 that directly follows a syn1. With strip_en low, such characters are delivered.
- R9: While framed through the internal match, a syn1 character sets syn_det again in single mode. In double mode, a syn1 followed directly by syn2 sets it again.
- R10: syn_det stays set until a status_rd pulse. If a new set happens in the same cycle, the set wins.
- R11: With ext_sync_en high, syn1 in the stream neither frames, strips nor sets syn_det. After a rising edge of ext_sync, the next bit strobe carries bit 0 of a character, and syn_det is set.
- R12: With par_en high, each character is followed by one parity bit that is not part of the data. parity_err is loaded with each delivered character. With par_odd low (even parity), it is set when the data bits and the parity bit hold an odd number of ones. With par_odd high (odd parity), it is set when they hold an even number. The parity bit after the matched syn1 is consumed unchecked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe marking a received bit |
| rxd | input | 1 | Serial data, valid with bit_en |
| rx_enable | input | 1 | Receiver enable; a rising edge starts a hunt |
| syn1 | input | DATA_W | First sync pattern |
| syn2 | input | DATA_W | Second sync pattern (double mode) |
| double_syn | input | 1 | Selects the two-character sync sequence |
| strip_en | input | 1 | Withhold sync characters after framing |
| ext_sync_en | input | 1 | Use ext_sync instead of pattern matching |
| ext_sync | input | 1 | External jam-sync; its rising edge frames the next bit |
| par_en | input | 1 | A parity bit follows each character |
| par_odd | input | 1 | Odd parity when high, even when low |
| data_rd | input | 1 | Host read of rx_data; clears rx_ready |
| status_rd | input | 1 | Host status read; clears syn_det and overrun |
| rx_data | output | DATA_W | Holding register with the last delivered character |
| rx_ready | output | 1 | A delivered character is waiting |
| parity_err | output | 1 | Parity result of the character in rx_data |
| overrun | output | 1 | A character was delivered over an unread one |
| syn_det | output | 1 | Sticky sync-detected flag |

## Verification
A wrong hunt position or bit count cannot be seen until a whole character has gone by. It then shows up at the ports as a byte with rotated bits, a missing rx_ready, or a syn_det that never rises. The bench therefore checks rx_data, rx_ready and syn_det at every character boundary. A wrong frame offset shows on the first data byte after the sync pattern. A mistake in the double-pattern state can take two characters to show, for example a false sync after syn1, syn1, syn2, which would appear as a syn_det or a delivered byte where none is expected. Parity bookkeeping errors show as a data byte that is one bit off, or as a wrong parity_err at the very next character.

// File: rtl/syncrx_pkg.sv
package syncrx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_SYN2 = 2'd2,
    ST_RUN  = 2'd3
  } rx_state_e;

endpackage

// File: rtl/syncrx_rstsync.sv
module syncrx_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= 2'b00;
    else        pipe_q <= {pipe_q[0], 1'b1};
  end

  assign rst_sync_n = pipe_q[1];
endmodule

// File: rtl/syncrx_edge.sv
module syncrx_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  logic [N-1:0] last_q;

  for (genvar i = 0; i < N; i++) begin : g_edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q[i] <= 1'b0;
      else        last_q[i] <= din[i];
    end
    assign rise[i] = din[i] & ~last_q[i];
  end
endmodule

// File: rtl/syncrx_deser.sv
module syncrx_deser #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              clr,
  input  logic              rxd,
  output logic [DATA_W-1:0] sr,
  output logic [DATA_W-1:0] sr_next
);
  logic [DATA_W-1:0] sr_q, sr_d;

  // newest bit enters at the top so the first bit ends up in bit 0
  assign sr_next = {rxd, sr_q[DATA_W-1:1]};

  always_comb begin
    sr_d = sr_q;
    if (clr)           sr_d = '0;
    else if (shift_en) sr_d = sr_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign sr = sr_q;
endmodule

// File: rtl/syncrx_ctrl.sv
module syncrx_ctrl
  import syncrx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rxd,
  input  logic              en,
  input  logic              en_rise,
  input  logic              xs_rise,
  input  logic              ext_en,
  input  logic              double_syn,
  input  logic              strip_en,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [DATA_W-1:0] syn1,
  input  logic [DATA_W-1:0] syn2,
  input  logic [DATA_W-1:0] sr,
  input  logic [DATA_W-1:0] sr_next,
  output logic              shift_en,
  output logic              sr_clr,
  output logic              load,
  output logic [DATA_W-1:0] load_data,
  output logic              load_perr,
  output logic              syn_set,
  output rx_state_e         state
);
  localparam logic [CNT_W-1:0] LAST_D  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] PAR_POS = CNT_W'(DATA_W);

  rx_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tail_q, tail_d;   // parity bit of the matched syn1 pending
  logic             prev_q, prev_d;   // last framed character was syn1
  logic             pend_q, pend_d;   // external sync waiting for a bit

  logic [DATA_W-1:0] char_w;
  logic              at_last, data_bit, is_syn1, is_syn2, perr_w;

  assign char_w   = par_en ? sr : sr_next;
  assign at_last  = par_en ? (cnt_q == PAR_POS) : (cnt_q == LAST_D);
  assign data_bit = (cnt_q < PAR_POS);
  assign is_syn1  = !ext_en && (char_w == syn1);
  assign is_syn2  = !ext_en && double_syn && prev_q && (char_w == syn2);
  assign perr_w   = par_en & ((^sr) ^ rxd ^ par_odd);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    tail_d   = tail_q;
    prev_d   = prev_q;
    pend_d   = pend_q;
    shift_en = 1'b0;
    sr_clr   = 1'b0;
    load     = 1'b0;
    syn_set  = 1'b0;
    if (!en || en_rise) begin
      st_d   = en ? ST_HUNT : ST_IDLE;
      cnt_d  = '0;
      tail_d = 1'b0;
      prev_d = 1'b0;
      pend_d = 1'b0;
      sr_clr = 1'b1;
    end else begin
      if (xs_rise && ext_en && st_q != ST_IDLE) pend_d = 1'b1;
      if (bit_en) begin
        if (ext_en && pend_q) begin
          st_d     = ST_RUN;
          pend_d   = xs_rise;
          shift_en = 1'b1;
          cnt_d    = CNT_W'(1);
          tail_d   = 1'b0;
          prev_d   = 1'b0;
          syn_set  = 1'b1;
        end else begin
          unique case (st_q)
            ST_HUNT: begin
              if (!ext_en) begin
                shift_en = 1'b1;
                if (sr_next == syn1) begin
                  syn_set = !double_syn;
                  st_d    = double_syn ? ST_SYN2 : ST_RUN;
                  cnt_d   = '0;
                  tail_d  = par_en;
                  prev_d  = 1'b0;
                end
              end
            end
            ST_SYN2, ST_RUN: begin
              if (tail_q) begin
                tail_d = 1'b0;
              end else begin
                shift_en = data_bit;
                if (at_last) begin
                  cnt_d = '0;
                  if (st_q == ST_SYN2) begin
                    if (char_w == syn2) begin
                      st_d    = ST_RUN;
                      syn_set = 1'b1;
                    end else begin
                      st_d = ST_HUNT;
                    end
                  end else begin
                    syn_set = double_syn ? is_syn2 : is_syn1;
                    prev_d  = is_syn1;
                    load    = !(strip_en && (is_syn1 || is_syn2));
                  end
                end else begin
                  cnt_d = cnt_q + CNT_W'(1);
                end
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      tail_q <= 1'b0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      tail_q <= tail_d;
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign load_data = char_w;
  assign load_perr = perr_w;
  assign state     = st_q;
endmodule

// File: rtl/syncrx_hunt.sv
module syncrx_hunt
  import syncrx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rxd,
  input  logic              rx_enable,
  input  logic [DATA_W-1:0] syn1,
  input  logic [DATA_W-1:0] syn2,
  input  logic              double_syn,
  input  logic              strip_en,
  input  logic              ext_sync_en,
  input  logic              ext_sync,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              data_rd,
  input  logic              status_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              parity_err,
  output logic              overrun,
  output logic              syn_det
);
  logic              rst_sync_n;
  logic [1:0]        rise;
  logic              shift_en, sr_clr, load, load_perr, syn_set;
  logic [DATA_W-1:0] sr, sr_next, load_data;
  rx_state_e         st;

  logic [DATA_W-1:0] data_q, data_d;
  logic              rdy_q, rdy_d, perr_q, perr_d, ovr_q, ovr_d, syn_q, syn_d;

  syncrx_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  syncrx_edge #(.N(2)) u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   ({ext_sync, rx_enable}),
    .rise  (rise)
  );

  syncrx_deser #(.DATA_W(DATA_W)) u_deser (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (shift_en),
    .clr      (sr_clr),
    .rxd      (rxd),
    .sr       (sr),
    .sr_next  (sr_next)
  );

  syncrx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bit_en     (bit_en),
    .rxd        (rxd),
    .en         (rx_enable),
    .en_rise    (rise[0]),
    .xs_rise    (rise[1]),
    .ext_en     (ext_sync_en),
    .double_syn (double_syn),
    .strip_en   (strip_en),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .syn1       (syn1),
    .syn2       (syn2),
    .sr         (sr),
    .sr_next    (sr_next),
    .shift_en   (shift_en),
    .sr_clr     (sr_clr),
    .load       (load),
    .load_data  (load_data),
    .load_perr  (load_perr),
    .syn_set    (syn_set),
    .state      (st)
  );

  always_comb begin
    data_d = load ? load_data : data_q;
    perr_d = load ? load_perr : perr_q;
    rdy_d  = load ? 1'b1 : (data_rd ? 1'b0 : rdy_q);
    ovr_d  = (load && rdy_q && !data_rd) ? 1'b1 : (status_rd ? 1'b0 : ovr_q);
    syn_d  = syn_set ? 1'b1 : (status_rd ? 1'b0 : syn_q);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      data_q <= '0;
      perr_q <= 1'b0;
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
      syn_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      perr_q <= perr_d;
      rdy_q  <= rdy_d;
      ovr_q  <= ovr_d;
      syn_q  <= syn_d;
    end
  end

  assign rx_data    = data_q;
  assign rx_ready   = rdy_q;
  assign parity_err = perr_q;
  assign overrun    = ovr_q;
  assign syn_det    = syn_q;
endmodule

// File: rtl/syncrx_hunt_chk.sv
module syncrx_hunt_chk
  import syncrx_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      rx_enable,
  input logic      ext_sync_en,
  input logic      data_rd,
  input logic      status_rd,
  input logic      load,
  input logic      rx_ready,
  input logic      overrun,
  input logic      syn_det,
  input rx_state_e st
);
  // R2: a low enable parks the receiver in idle
  a_r2_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> st == ST_IDLE);

  // R2: a rising enable starts the hunt
  a_r2_hunt_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_enable) |=> st == ST_HUNT);

  // R6: a read with no new character clears the ready flag
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !load) |=> !rx_ready);

  // R6: delivery only happens while framed
  a_r6_load_framed: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> st == ST_RUN);

  // R7: delivery over an unread character flags overrun
  a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (load && rx_ready && !data_rd) |=> overrun);

  // R10: sync flag holds until a status read
  a_r10_syn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_det && !status_rd) |=> syn_det);

  // R11: external mode never enters the second-pattern wait
  a_r11_no_syn2_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sync_en && st == ST_HUNT) |=> st != ST_SYN2);
endmodule

bind syncrx_hunt syncrx_hunt_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .rx_enable   (rx_enable),
  .ext_sync_en (ext_sync_en),
  .data_rd     (data_rd),
  .status_rd   (status_rd),
  .load        (load),
  .rx_ready    (rx_ready),
  .overrun     (overrun),
  .syn_det     (syn_det),
  .st          (st)
);

// File: tb/syncrx_hunt_tb.sv
module syncrx_hunt_tb;
  localparam int W = 8;
  localparam logic [W-1:0] S1 = 8'h16;
  localparam logic [W-1:0] S2 = 8'h2B;
  // {byte sent, expected rx_ready, expected rx_data, expected syn_det}
  localparam int NV = 7;
  localparam logic [17:0] VEC [NV] = '{
    {8'hFF, 1'b0, 8'h00, 1'b0},
    {8'h16, 1'b0, 8'h00, 1'b1},
    {8'h41, 1'b1, 8'h41, 1'b0},
    {8'h16, 1'b0, 8'h00, 1'b1},
    {8'hA5, 1'b1, 8'hA5, 1'b0},
    {8'h00, 1'b1, 8'h00, 1'b0},
    {8'h3C, 1'b1, 8'h3C, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, rxd = 1'b1, rx_enable = 1'b0;
  logic double_syn = 1'b0, strip_en = 1'b1, ext_sync_en = 1'b0, ext_sync = 1'b0;
  logic par_en = 1'b0, par_odd = 1'b0, data_rd = 1'b0, status_rd = 1'b0;
  logic [W-1:0] rx_data;
  logic rx_ready, parity_err, overrun, syn_det;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  syncrx_hunt #(.DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rxd(rxd), .rx_enable(rx_enable),
    .syn1(S1), .syn2(S2), .double_syn(double_syn), .strip_en(strip_en),
    .ext_sync_en(ext_sync_en), .ext_sync(ext_sync), .par_en(par_en), .par_odd(par_odd),
    .data_rd(data_rd), .status_rd(status_rd), .rx_data(rx_data), .rx_ready(rx_ready),
    .parity_err(parity_err), .overrun(overrun), .syn_det(syn_det)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rxd = b; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
  endtask

  task automatic send_byte(input logic [W-1:0] v);
    for (int i = 0; i < W; i++) send_bit(v[i]);
  endtask

  task automatic pulse_rd();
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic pulse_st();
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk); rx_enable = 1'b0;
    @(negedge clk); rx_enable = 1'b1;
    pulse_rd(); pulse_st();
  endtask

  // checks ready, data and sync flag, then consumes both
  task automatic expect_rx(input string req, input logic rdy, input logic [W-1:0] d,
                           input logic syn);
    chk(rx_ready == rdy, req, "rx_ready", 32'(rx_ready), 32'(rdy));
    if (rdy) chk(rx_data == d, req, "rx_data", 32'(rx_data), 32'(d));
    chk(syn_det == syn, req, "syn_det", 32'(syn_det), 32'(syn));
    if (rx_ready) pulse_rd();
    pulse_st();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(rx_data == '0, "R1", "rx_data", 32'(rx_data), 0);
    chk(!rx_ready && !parity_err && !overrun && !syn_det, "R1", "flags",
        {rx_ready, parity_err, overrun, syn_det}, 0);

    // R4 R6 R8 R9 single mode with stripping, table driven
    rx_enable = 1'b1;
    send_byte(8'hFF);
    for (int v = 0; v < NV; v++) begin
      send_byte(VEC[v][17:10]);
      expect_rx("R4/R6/R8/R9 table", VEC[v][9], VEC[v][8:1], VEC[v][0]);
    end

    // R7 overrun then cleared by status read
    send_byte(8'h11);
    send_byte(8'h22);
    chk(overrun == 1'b1, "R7", "overrun", 32'(overrun), 1);
    chk(rx_data == 8'h22, "R7", "rx_data", 32'(rx_data), 32'h22);
    pulse_rd(); pulse_st();
    chk(overrun == 1'b0, "R7", "overrun cleared", 32'(overrun), 0);

    // R8 R9 no stripping: syn1 delivered and flagged
    strip_en = 1'b0;
    send_byte(S1);
    expect_rx("R8 nostrip", 1'b1, S1, 1'b1);
    strip_en = 1'b1;

    // R2 disabled receiver ignores the stream
    @(negedge clk); rx_enable = 1'b0;
    send_byte(S1); send_byte(8'h5A);
    expect_rx("R2 off", 1'b0, 8'h00, 1'b0);
    @(negedge clk); rx_enable = 1'b1;
    send_byte(8'h5A);
    expect_rx("R2 rehunt", 1'b0, 8'h00, 1'b0);

    // R3 match at an odd bit offset
    restart();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    send_byte(S1);
    send_byte(8'h5A);
    expect_rx("R3 offset", 1'b1, 8'h5A, 1'b1);

    // R5 double mode: syn1 syn1 syn2 fails, syn1 syn2 frames
    double_syn = 1'b1;
    restart();
    send_byte(8'hFF);
    send_byte(S1); send_byte(S1); send_byte(S2); send_byte(8'hFF);
    expect_rx("R5 no sync", 1'b0, 8'h00, 1'b0);
    send_byte(S1); send_byte(S2);
    expect_rx("R5 sync", 1'b0, 8'h00, 1'b1);
    send_byte(8'h77);
    expect_rx("R5 data", 1'b1, 8'h77, 1'b0);
    // R9 R8 double re-detect with stripping
    send_byte(S1);
    expect_rx("R9 half", 1'b0, 8'h00, 1'b0);
    send_byte(S2);
    expect_rx("R9 double", 1'b0, 8'h00, 1'b1);
    double_syn = 1'b0;

    // R11 R10 external jam sync
    ext_sync_en = 1'b1;
    restart();
    send_byte(S1); send_byte(8'h55);
    expect_rx("R11 no match", 1'b0, 8'h00, 1'b0);
    @(negedge clk); ext_sync = 1'b1;
    @(negedge clk); ext_sync = 1'b0;
    send_byte(8'hC3);
    chk(rx_ready && rx_data == 8'hC3, "R11", "jam data", 32'(rx_data), 32'hC3);
    chk(syn_det == 1'b1, "R11", "syn_det", 32'(syn_det), 1);
    pulse_rd();
    send_byte(S1);
    chk(rx_ready && rx_data == S1, "R11", "no strip", 32'(rx_data), 32'(S1));
    chk(syn_det == 1'b1, "R10", "sticky", 32'(syn_det), 1);
    pulse_rd(); pulse_st();
    chk(syn_det == 1'b0, "R10", "cleared", 32'(syn_det), 0);
    ext_sync_en = 1'b0;

    // R12 parity
    par_en = 1'b1;
    restart();
    send_byte(8'hFF); send_bit(1'b1);
    send_byte(S1); send_bit(1'b1);
    send_byte(8'h5A); send_bit(1'b0);
    chk(rx_ready && rx_data == 8'h5A, "R12", "data", 32'(rx_data), 32'h5A);
    chk(parity_err == 1'b0, "R12", "even ok", 32'(parity_err), 0);
    pulse_rd();
    send_byte(8'h5B); send_bit(1'b0);
    chk(rx_data == 8'h5B, "R12", "data2", 32'(rx_data), 32'h5B);
    chk(parity_err == 1'b1, "R12", "even bad", 32'(parity_err), 1);
    pulse_rd();
    par_odd = 1'b1;
    send_byte(8'h5B); send_bit(1'b0);
    chk(parity_err == 1'b0, "R12", "odd ok", 32'(parity_err), 0);
    pulse_rd();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule